// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Byte-Wide SRAM

This block lets synchronous logic use an external asynchronous static RAM. A single request carries an address, a write flag and write data. It is accepted only while the controller signals ready. The controller then drives the memory address, the active-low chip-enable, output-enable and write-enable strobes, and the enable of the shared data bus. For a read, the controller captures the returned byte and presents it with a one-cycle valid pulse.

Every strobe phase lasts a whole number of clock cycles. The controller derives these counts at elaboration time from a table of asynchronous limits for two speed grades (0 is the faster grade, 1 the slower). Each limit is converted by ceiling division of nanoseconds by the clock period. Write enable always ends a write. Chip enable is released one cycle after write enable rises. After a read, the controller holds a recovery phase so that the memory has released the bus before the controller can drive it again.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycle after it, req_ready is 1, the three strobes are 1 (inactive), sram_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken on a rising clock edge where req_valid and req_ready are both 1. From that edge, req_ready stays 0 until the transaction and any recovery phase have ended. req_ready is 1 only while all strobes are inactive.
- R3: A read (req_write = 0) drives sram_ce_n and sram_oe_n to 0 from the accepting edge for RD cycles. RD is the largest of the converted read-cycle, address-access, enable-access and output-enable-access limits; it is 3 at grade 0 with a 20 ns clock. sram_we_n stays 1 whenever sram_oe_n is 0.
- R4: At the edge that ends the read strobes, the controller captures sram_dq_in into rsp_rdata and drives rsp_valid to 1 for exactly one cycle. With the defaults, this is the third edge after acceptance.
- R5: After a read, req_ready stays 0 for REC cycles, the converted bus-release limit (at least 1), before the next request can be taken. With the defaults, req_ready is 1 again four cycles after acceptance.
- R6: A write (req_write = 1) drives sram_ce_n and sram_we_n to 0 and sram_dq_oe to 1 from the accepting edge for WR cycles. WR is the largest of the converted pulse-width, address-setup-to-end and data-setup-to-end limits and of the write cycle count minus one; it is 3 with the defaults. sram_oe_n stays 1 throughout the write.
- R7: Write enable ends every write. sram_dq_oe falls on the same edge as sram_we_n rises. sram_ce_n rises one edge later, so chip enable is low for WR+1 cycles.
- R8: sram_addr and sram_dq_out do not change while sram_ce_n is 0.
- R9: sram_dq_oe is 1 only while sram_oe_n is 1, and never sooner than the bus-release limit after sram_oe_n last rose.
- R10: A request presented while req_ready is 0 is ignored. No strobe is started for it, and the memory contents at its address are unchanged.
- R11: The memory's analog limits are met at the default settings. Read data is sampled no earlier than 55 ns after the strobes fall. The write-enable pulse lasts at least 40 ns. The address is set up at least 45 ns and the data at least 25 ns before write enable rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Memory address of the request |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Captured read data |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data bus pads |
| sram_dq_in | input | DATA_W | Data received from the memory |

## Verification
The checker assumes that req_valid is only meaningful in the idle state. It assumes that sram_dq_in is whatever the memory returns, with no constraint on when it settles. No property depends on the user holding a request stable, so the properties hold whatever req_valid, req_write and req_addr do. The stimulus keeps requests, including one deliberately held high while the controller is busy, aligned to falling clock edges. The behavioural memory model in the bench supplies a poison byte until 55 ns after both read strobes fall. It measures every write-enable pulse and every bus turnaround in nanoseconds against the grade 0 limits.

// File: rtl/sram_timing_pkg.sv
package sram_timing_pkg;

   // Names of the asynchronous limits kept in the grade table
   typedef enum logic [3:0] {
      LIM_RC, LIM_AA, LIM_ACE, LIM_DOE, LIM_HZ,
      LIM_PWE, LIM_AW, LIM_SD, LIM_WC
   } lim_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD      = 3'd1,
      ST_RD_REC  = 3'd2,
      ST_WR      = 3'd3,
      ST_WR_HOLD = 3'd4
   } seq_state_t;

   // Nanosecond limit for one grade (0 = fast, 1 = slow)
   function automatic int unsigned limit_ns(input int unsigned grade, input lim_e which);
      int unsigned v;
      v = 0;
      case (which)
         LIM_RC  : v = (grade == 0) ? 55 : 70;
         LIM_AA  : v = (grade == 0) ? 55 : 70;
         LIM_ACE : v = (grade == 0) ? 55 : 70;
         LIM_DOE : v = (grade == 0) ? 25 : 35;
         LIM_HZ  : v = (grade == 0) ? 20 : 25;
         LIM_PWE : v = (grade == 0) ? 40 : 50;
         LIM_AW  : v = (grade == 0) ? 45 : 60;
         LIM_SD  : v = (grade == 0) ? 25 : 30;
         LIM_WC  : v = (grade == 0) ? 55 : 70;
         default : v = 0;
      endcase
      return v;
   endfunction

   // Ceiling conversion; a nonzero limit never rounds to zero cycles
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      if (ns == 0) return 0;
      return (ns + period - 1) / period;
   endfunction

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_ctr.sv
module sram_phase_ctr #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_timing_pkg::*;
#(
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned RD_CYC  = 3,
   parameter int unsigned WR_CYC  = 3,
   parameter int unsigned REC_CYC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             ctr_last,
   output logic             req_ready,
   output logic             accept,
   output logic             rd_done,
   output logic             ctr_load,
   output logic [CNT_W-1:0] ctr_val,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe
);

   seq_state_t state;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign rd_done   = (state == ST_RD) && ctr_last;
   assign ctr_load  = accept || rd_done;

   always_comb begin
      if (rd_done)        ctr_val = CNT_W'(REC_CYC);
      else if (req_write) ctr_val = CNT_W'(WR_CYC);
      else                ctr_val = CNT_W'(RD_CYC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  ce_n <= 1'b0;
                  if (req_write) begin
                     state <= ST_WR;
                     we_n  <= 1'b0;
                     dq_oe <= 1'b1;
                  end else begin
                     state <= ST_RD;
                     oe_n  <= 1'b0;
                  end
               end
            end
            ST_RD: begin
               if (ctr_last) begin
                  ce_n  <= 1'b1;
                  oe_n  <= 1'b1;
                  state <= ST_RD_REC;
               end
            end
            ST_RD_REC: begin
               if (ctr_last) state <= ST_IDLE;
            end
            ST_WR: begin
               if (ctr_last) begin
                  we_n  <= 1'b1;
                  dq_oe <= 1'b0;
                  state <= ST_WR_HOLD;
               end
            end
            ST_WR_HOLD: begin
               ce_n  <= 1'b1;
               state <= ST_IDLE;
            end
            default: begin
               state <= ST_IDLE;
               ce_n  <= 1'b1;
               oe_n  <= 1'b1;
               we_n  <= 1'b1;
               dq_oe <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sram_xfer_dp.sv
module sram_xfer_dp #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              rd_done,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         dq_out   <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
         dq_out   <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_done;
         if (rd_done) rsp_rdata <= dq_in;
      end
   end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_timing_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 20,
   parameter int unsigned GRADE         = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);

   // Limits converted to cycles
   localparam int unsigned T_RC  = ns_to_cyc(limit_ns(GRADE, LIM_RC),  CLK_PERIOD_NS);
   localparam int unsigned T_AA  = ns_to_cyc(limit_ns(GRADE, LIM_AA),  CLK_PERIOD_NS);
   localparam int unsigned T_ACE = ns_to_cyc(limit_ns(GRADE, LIM_ACE), CLK_PERIOD_NS);
   localparam int unsigned T_DOE = ns_to_cyc(limit_ns(GRADE, LIM_DOE), CLK_PERIOD_NS);
   localparam int unsigned T_HZ  = ns_to_cyc(limit_ns(GRADE, LIM_HZ),  CLK_PERIOD_NS);
   localparam int unsigned T_PWE = ns_to_cyc(limit_ns(GRADE, LIM_PWE), CLK_PERIOD_NS);
   localparam int unsigned T_AW  = ns_to_cyc(limit_ns(GRADE, LIM_AW),  CLK_PERIOD_NS);
   localparam int unsigned T_SD  = ns_to_cyc(limit_ns(GRADE, LIM_SD),  CLK_PERIOD_NS);
   localparam int unsigned T_WC  = ns_to_cyc(limit_ns(GRADE, LIM_WC),  CLK_PERIOD_NS);

   // Phase lengths: read strobes, write pulse (hold cycle adds one), bus recovery
   localparam int unsigned RD_CYC  = imax(imax(T_AA, T_ACE), imax(T_DOE, T_RC));
   localparam int unsigned WR_CYC  = imax(imax(T_PWE, T_AW),
                                          imax(T_SD, (T_WC > 1) ? T_WC - 1 : 1));
   localparam int unsigned REC_CYC = imax(T_HZ, 1);
   localparam int unsigned CNT_W   = $clog2(imax(RD_CYC, imax(WR_CYC, REC_CYC)) + 1);

   generate
      if (GRADE > 1) begin : g_bad_grade
         $error("sram_strobe_ctrl: GRADE must be 0 or 1");
      end
      if (CLK_PERIOD_NS == 0) begin : g_bad_clk
         $error("sram_strobe_ctrl: CLK_PERIOD_NS must be nonzero");
      end
      if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
         $error("sram_strobe_ctrl: widths must be nonzero");
      end
   endgenerate

   logic             accept;
   logic             rd_done;
   logic             ctr_load;
   logic             ctr_last;
   logic [CNT_W-1:0] ctr_val;

   sram_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (ctr_val),
      .last     (ctr_last)
   );

   sram_seq #(
      .CNT_W   (CNT_W),
      .RD_CYC  (RD_CYC),
      .WR_CYC  (WR_CYC),
      .REC_CYC (REC_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .ctr_last  (ctr_last),
      .req_ready (req_ready),
      .accept    (accept),
      .rd_done   (rd_done),
      .ctr_load  (ctr_load),
      .ctr_val   (ctr_val),
      .ce_n      (sram_ce_n),
      .oe_n      (sram_oe_n),
      .we_n      (sram_we_n),
      .dq_oe     (sram_dq_oe)
   );

   sram_xfer_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .rd_done   (rd_done),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (sram_dq_in),
      .mem_addr  (sram_addr),
      .dq_out    (sram_dq_out),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
   parameter int unsigned AW = 15,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] dq_out,
   input logic          ce_n,
   input logic          oe_n,
   input logic          we_n,
   input logic          dq_oe
);

   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ce_n && oe_n && we_n)); // R2

   AST_READ_KEEPS_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> we_n); // R3

   AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R4

   AST_RSP_AT_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(oe_n)); // R4

   AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n); // R6

   AST_CE_RISES_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_n) |-> $past(we_n)); // R7

   AST_DRIVE_DROPS_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> !dq_oe); // R7

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(dq_out))); // R8

   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n); // R9

   AST_NO_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_n) |-> !dq_oe); // R9

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .addr      (sram_addr),
   .dq_out    (sram_dq_out),
   .ce_n      (sram_ce_n),
   .oe_n      (sram_oe_n),
   .we_n      (sram_we_n),
   .dq_oe     (sram_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

   localparam int AW = 15;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [DW-1:0] sram_dq_out;
   logic [DW-1:0] sram_dq_in;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   sram_strobe_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
      .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
      .sram_dq_in(sram_dq_in)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural memory with timing checks ----------------
   logic [DW-1:0] mem [256];
   logic  data_ok = 1'b0;
   realtime t_we_fall = 0.0, t_addr = 0.0, t_data = 0.0, t_oe_rise = -1000.0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;

   assign sram_dq_in = data_ok ? mem[sram_addr[7:0]] : 8'hEE;

   always @(sram_addr) t_addr = $realtime;
   always @(sram_dq_out or posedge sram_dq_oe) t_data = $realtime;
   always @(negedge sram_we_n) t_we_fall = $realtime;
   always @(posedge sram_oe_n) t_oe_rise = $realtime;

   always begin
      wait (!sram_ce_n && !sram_oe_n);
      #55;
      if (!sram_ce_n && !sram_oe_n) data_ok = 1'b1;
      wait (sram_ce_n || sram_oe_n);
      data_ok = 1'b0;
   end

   always @(posedge sram_we_n) begin
      if (rst_n && !sram_ce_n) begin
         chk("R11", "we pulse >= 40ns", int'($realtime - t_we_fall >= 40.0), 1);
         chk("R11", "addr setup >= 45ns", int'($realtime - t_addr >= 45.0), 1);
         chk("R11", "data setup >= 25ns", int'($realtime - t_data >= 25.0), 1);
         mem[sram_addr[7:0]] = sram_dq_out;
      end
   end

   always @(posedge sram_ce_n) begin
      if (rst_n) chk("R7", "we high before ce rises", int'(sram_we_n), 1);
   end

   always @(posedge sram_dq_oe) begin
      chk("R9", "oe high while driving", int'(sram_oe_n), 1);
      chk("R9", "bus release >= 20ns", int'($realtime - t_oe_rise >= 20.0), 1);
   end

   // ---------------- stimulus helpers ----------------
   int o_ce, o_oe, o_we, o_drv, o_rsp_k, o_rsp_n, o_rdy_k, o_bad_we, o_bad_oe;
   logic [DW-1:0] o_data;

   // Present a request at a falling edge; it is taken at the next rising edge.
   task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
   endtask

   // Sample at falling edges k = 0..7 after the accepting edge.
   task automatic observe(input logic drop_now);
      o_ce = 0; o_oe = 0; o_we = 0; o_drv = 0; o_rsp_k = -1; o_rsp_n = 0;
      o_rdy_k = -1; o_bad_we = 0; o_bad_oe = 0; o_data = '0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (k == 0 && drop_now) req_valid = 1'b0;
         if (!sram_ce_n) o_ce++;
         if (!sram_oe_n) o_oe++;
         if (!sram_we_n) o_we++;
         if (sram_dq_oe) o_drv++;
         if (!sram_oe_n && !sram_we_n) o_bad_we++;
         if (!sram_we_n && !sram_oe_n) o_bad_oe++;
         if (rsp_valid) begin
            o_rsp_n++;
            if (o_rsp_k < 0) begin o_rsp_k = k; o_data = rsp_rdata; end
         end
         if (req_ready && o_rdy_k < 0) o_rdy_k = k;
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      issue(1'b0, a, '0);
      observe(1'b1);
      d = o_data;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      issue(1'b1, a, d);
      observe(1'b1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      @(negedge clk);
      chk("R1", "ready in reset", int'(req_ready), 1);
      chk("R1", "ce_n in reset", int'(sram_ce_n), 1);
      chk("R1", "oe_n in reset", int'(sram_oe_n), 1);
      chk("R1", "we_n in reset", int'(sram_we_n), 1);
      chk("R1", "dq_oe in reset", int'(sram_dq_oe), 0);
      chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", int'(req_ready), 1);
      chk("R1", "strobes idle after reset", int'(sram_ce_n & sram_oe_n & sram_we_n), 1);
   endtask

   task automatic t_read_timing();
      logic [DW-1:0] d;
      do_read(15'h0042, d);
      chk("R3", "oe low cycles", o_oe, 3);
      chk("R3", "ce low cycles on read", o_ce, 3);
      chk("R3", "we low during read", o_we, 0);
      chk("R4", "rsp_valid cycle", o_rsp_k, 3);
      chk("R4", "rsp_valid width", o_rsp_n, 1);
      chk("R4", "read data", int'(d), int'(8'h42 ^ 8'h3C));
      chk("R5", "ready return after read", o_rdy_k, 4);
      chk("R9", "no drive during read", o_drv, 0);
   endtask

   task automatic t_write_timing();
      do_write(15'h0007, 8'hC3);
      chk("R6", "we low cycles", o_we, 3);
      chk("R6", "drive cycles", o_drv, 3);
      chk("R6", "oe low during write", o_oe, 0);
      chk("R7", "ce low cycles on write", o_ce, 4);
      chk("R2", "ready return after write", o_rdy_k, 4);
      chk("R6", "model stored byte", int'(mem[7]), int'(8'hC3));
   endtask

   task automatic t_patterns();
      logic [DW-1:0] d;
      logic [7:0] pa [4] = '{8'h00, 8'h01, 8'hFF, 8'h80};
      logic [7:0] pd [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h00};
      for (int i = 0; i < 4; i++) do_write({7'h00, pa[i]}, pd[i]);
      for (int i = 3; i >= 0; i--) begin
         do_read({7'h00, pa[i]}, d);
         chk("R4", "pattern readback", int'(d), int'(pd[i]));
         chk("R8", "read of written addr arrives", o_rsp_k, 3);
      end
   endtask

   task automatic t_busy_ignored();
      logic [DW-1:0] d;
      issue(1'b1, 15'h0010, 8'h11);
      // keep a second write to another address pending while busy
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0020; req_wdata = 8'h99;
      @(negedge clk);
      chk("R10", "ready low while busy", int'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);   // k = 3, hold cycle
      @(negedge clk);   // k = 4
      chk("R10", "no new strobe k4", int'(sram_ce_n), 1);
      @(negedge clk);
      chk("R10", "no new strobe k5", int'(sram_ce_n), 1);
      chk("R10", "address unchanged", int'(sram_addr), 16'h0010);
      do_read(15'h0020, d);
      chk("R10", "ignored write left memory", int'(d), int'(8'h20 ^ 8'h3C));
      do_read(15'h0010, d);
      chk("R6", "accepted write landed", int'(d), int'(8'h11));
   endtask

   task automatic t_back_to_back();
      logic [DW-1:0] d;
      do_write(15'h0033, 8'h77);
      do_read(15'h0033, d);
      chk("R4", "read right after write", int'(d), int'(8'h77));
      do_write(15'h0034, 8'h88);   // bus turnaround after a read
      chk("R9", "write after read drive cycles", o_drv, 3);
      do_read(15'h0034, d);
      chk("R11", "read after turnaround", int'(d), int'(8'h88));
   endtask

   initial begin
      #(200000 * 20);
      chk("WATCHDOG", "run finished in time", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_read_timing();
      t_write_timing();
      t_patterns();
      t_busy_ignored();
      t_back_to_back();
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule